// File: doc/BRIEF.md
# Host Bus Register-Core Selector

This block sits between a single host bus and a small set of register cores inside a larger design. Each bus access carries a 24-bit address. The upper sixteen bits name a core by number, and the lower eight bits name a register inside that core. Write and read requests are one-cycle strobes. Write data is sampled together with the write strobe.

Reads do not complete combinationally. The request is registered first. The selected core then answers from a registered output. The answers of all cores are merged and registered once more before they reach the read-data port. A read therefore completes a fixed number of cycles after its strobe, and the read-data port keeps its value between reads.

Two scratch-register cores are built in so that address decoding can be exercised. Core 0x0000 has a scratch register at offset 0xFF, and core 0x0037 has one at offset 0x0F. An access that finds no register raises a one-cycle error flag at the point where its result would appear. A cycle that carries both strobes at once also raises that flag.

Top module: `bus_core_selector`

## Requirements
- R1: The address is split as core number = addr[23:8] and register offset = addr[7:0]. A register is reached only when both fields match it.
- R2: Core 0x0000 holds a 32-bit read/write scratch register at offset 0xFF. A read returns the last value written to it.
- R3: Core 0x0037 holds a 32-bit read/write scratch register at offset 0x0F. A write to either scratch register never changes the other one.
- R4: If the read strobe is sampled at rising edge k, the read data is on `bus_rdata` right after edge k+2. `bus_rdata` holds that value until the next read completes. A read strobe in the cycle right after a write sees the written value.
- R5: An access to an unimplemented core number, or to an undefined offset in an implemented core, drives `bus_err` high for exactly the one cycle after edge k+2. A failing read sets `bus_rdata` to zero, and a failing write changes no register.
- R6: If both strobes are high in the same cycle, `bus_err` goes high at the same latency. No register is written, and `bus_rdata` keeps its previous value.
- R7: While `rst_n` is low, `bus_rdata` and `bus_err` are zero. Both scratch registers read back zero after reset.
- R8: `bus_err` is low in every cycle that is not the result cycle of a failing access. This includes the result cycles of successful reads and writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Reset, active low, synchronous |
| bus_addr | input | 24 | Core number (upper 16 bits) and register offset (lower 8 bits) |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wdata | input | 32 | Write data, valid with the write strobe |
| bus_rdata | output | 32 | Read result, held between reads |
| bus_err | output | 1 | One-cycle error pulse at the result cycle of a failing access |

## Verification
A wrong decode or a corrupted scratch register shows up at the ports on the next read of the register concerned, three edges after that read's strobe. It appears as a value on `bus_rdata` that does not match the value last written. A pipeline stage that is lost or duplicated moves the result or the error pulse by one cycle, and the bench sees this in the very cycle it happens because it compares both outputs against its own delay-line model on every clock. A conflict or miss that is handled wrongly shows up in the same result cycle, either as a missing error pulse or as a change of the held read data.

// File: rtl/csel_pkg.sv
package csel_pkg;

    localparam int CORE_W  = 16;
    localparam int OFFS_W  = 8;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = CORE_W + OFFS_W;
    localparam int N_CORES = 2;

    // entry i describes core i
    localparam logic [N_CORES-1:0][CORE_W-1:0] CORE_ID  = {16'h0037, 16'h0000};
    localparam logic [N_CORES-1:0][OFFS_W-1:0] SCR_OFFS = {8'h0F, 8'hFF};

    // request stage: strobes decoded and registered
    typedef struct packed {
        logic               rd;
        logic               wr;
        logic               clash;
        logic [N_CORES-1:0] sel;
        logic [OFFS_W-1:0]  offs;
        logic [DATA_W-1:0]  wdata;
    } req_t;

    // response stage: what the merge stage must report
    typedef struct packed {
        logic valid;
        logic rd;
        logic clash;
    } rsp_t;

endpackage

// File: rtl/scratch_core.sv
module scratch_core
    import csel_pkg::*;
#(
    parameter logic [OFFS_W-1:0] REG_OFFS = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_rd,
    input  logic [OFFS_W-1:0] offs,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [DATA_W-1:0] scr;
        logic              ack;
        logic [DATA_W-1:0] rdata;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     hit;

    always_comb begin
        st_d     = st_q;
        hit      = acc_en && (offs == REG_OFFS);
        st_d.ack = hit;
        // zero when idle so the merge stage can OR all cores together
        st_d.rdata = '0;
        if (hit && acc_rd) begin
            st_d.rdata = st_q.scr;
        end
        if (hit && !acc_rd) begin
            st_d.scr = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack   = st_q.ack;
    assign rdata = st_q.rdata;

endmodule

// File: rtl/csel_read_merge.sv
module csel_read_merge
    import csel_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  rsp_t                            rsp,
    input  logic [N_CORES-1:0]              core_ack,
    input  logic [N_CORES-1:0][DATA_W-1:0]  core_data,
    output logic [DATA_W-1:0]               rdata,
    output logic                            err
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              err;
    } mrg_st_t;

    mrg_st_t           st_d, st_q;
    logic [DATA_W-1:0] merged;
    logic              any_ack;

    always_comb begin
        merged  = '0;
        any_ack = 1'b0;
        for (int i = 0; i < N_CORES; i++) begin
            merged  = merged | core_data[i];
            any_ack = any_ack | core_ack[i];
        end

        st_d     = st_q;
        st_d.err = rsp.valid && (rsp.clash || !any_ack);
        if (rsp.valid && rsp.rd && !rsp.clash) begin
            st_d.rdata = any_ack ? merged : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;
    assign err   = st_q.err;

endmodule

// File: rtl/bus_core_selector.sv
module bus_core_selector
    import csel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err
);

    typedef struct packed {
        req_t req;
        rsp_t rsp;
    } top_st_t;

    top_st_t                       st_d, st_q;
    logic [CORE_W-1:0]             core_num;
    logic [N_CORES-1:0]            match;
    logic [N_CORES-1:0]            core_ack;
    logic [N_CORES-1:0][DATA_W-1:0] core_data;

    assign core_num = bus_addr[ADDR_W-1:OFFS_W];

    always_comb begin
        for (int i = 0; i < N_CORES; i++) begin
            match[i] = (core_num == CORE_ID[i]);
        end

        st_d = st_q;

        // stage 1: register the request
        st_d.req.rd    = bus_rd && !bus_wr;
        st_d.req.wr    = bus_wr && !bus_rd;
        st_d.req.clash = bus_rd && bus_wr;
        st_d.req.sel   = match;
        st_d.req.offs  = bus_addr[OFFS_W-1:0];
        st_d.req.wdata = bus_wdata;

        // stage 2: travels alongside the core responses
        st_d.rsp.valid = st_q.req.rd || st_q.req.wr || st_q.req.clash;
        st_d.rsp.rd    = st_q.req.rd;
        st_d.rsp.clash = st_q.req.clash;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < N_CORES; g++) begin : g_core
        scratch_core #(
            .REG_OFFS (SCR_OFFS[g])
        ) u_core (
            .clk    (clk),
            .rst_n  (rst_n),
            .acc_en ((st_q.req.rd || st_q.req.wr) && st_q.req.sel[g]),
            .acc_rd (st_q.req.rd),
            .offs   (st_q.req.offs),
            .wdata  (st_q.req.wdata),
            .ack    (core_ack[g]),
            .rdata  (core_data[g])
        );
    end

    csel_read_merge u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .rsp       (st_q.rsp),
        .core_ack  (core_ack),
        .core_data (core_data),
        .rdata     (bus_rdata),
        .err       (bus_err)
    );

endmodule

// File: rtl/csel_checker.sv
module csel_checker
    import csel_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_err
);

    logic bad_core_rd;
    logic good_wr;
    assign bad_core_rd = bus_rd && !bus_wr
                         && (bus_addr[ADDR_W-1:OFFS_W] != CORE_ID[0])
                         && (bus_addr[ADDR_W-1:OFFS_W] != CORE_ID[1]);
    assign good_wr     = bus_wr && !bus_rd
                         && (bus_addr == {CORE_ID[0], SCR_OFFS[0]});

    AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_rd || bus_wr, 3)); // R8

    AST_CLASH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_wr) |-> ##3 bus_err); // R6

    AST_CLASH_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && bus_wr, 3) |-> $stable(bus_rdata)); // R6

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd, 3) |-> $stable(bus_rdata)); // R4

    AST_BAD_CORE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bad_core_rd, 3) |-> (bus_err && bus_rdata == '0)); // R5

    AST_GOOD_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(good_wr, 3) |-> !bus_err); // R8

endmodule

bind bus_core_selector csel_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err)
);

// File: tb/tb_bus_core_selector.sv
`timescale 1ns / 1ps
module tb_bus_core_selector;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;

    always #4 clk = ~clk;

    bus_core_selector dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // behavioural model
    logic [31:0] m_a, m_b;
    logic [31:0] exp_rdata;
    bit          dv [3];
    bit          de [3];
    bit          dr [3];
    logic [31:0] dd [3];
    string       tag = "R7";

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %h expected %h", t, $time, act, exp);
        end
    endtask

    task automatic model_edge();
        bit v, e, r;
        logic [31:0] d;
        v = 0; e = 0; r = 0; d = '0;
        if (bus_rd && bus_wr) begin
            v = 1; e = 1;
        end else if (bus_rd) begin
            v = 1; r = 1;
            if (bus_addr == 24'h0000FF)      d = m_a;
            else if (bus_addr == 24'h00370F) d = m_b;
            else                             e = 1;
        end else if (bus_wr) begin
            v = 1;
            if (bus_addr == 24'h0000FF)      m_a = bus_wdata;
            else if (bus_addr == 24'h00370F) m_b = bus_wdata;
            else                             e = 1;
        end
        for (int i = 2; i > 0; i--) begin
            dv[i] = dv[i-1]; de[i] = de[i-1]; dr[i] = dr[i-1]; dd[i] = dd[i-1];
        end
        dv[0] = v; de[0] = e; dr[0] = r; dd[0] = d;
        if (dv[2] && dr[2] && !de[2]) exp_rdata = dd[2];
        if (dv[2] && dr[2] && de[2])  exp_rdata = '0;
    endtask

    // one clock: model the edge just passed, compare, then drive the next inputs
    task automatic cyc(input bit rd, input bit wr, input logic [23:0] a, input logic [31:0] d);
        @(negedge clk);
        model_edge();
        chk({tag, " rdata"}, bus_rdata, exp_rdata);
        chk({tag, " err"}, {31'b0, bus_err}, {31'b0, dv[2] && de[2]});
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 24'h0, 32'h0);
    endtask

    initial begin
        m_a = '0; m_b = '0; exp_rdata = '0;
        for (int i = 0; i < 3; i++) begin dv[i] = 0; de[i] = 0; dr[i] = 0; dd[i] = '0; end
        // R7: outputs zero while in reset
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R7 reset rdata", bus_rdata, 32'h0);
            chk("R7 reset err", {31'b0, bus_err}, 32'h0);
        end
        rst_n = 1'b1;
        tag = "R7";
        cyc(1, 0, 24'h0000FF, 0); cyc(1, 0, 24'h00370F, 0); idle(4);
        tag = "R2";
        cyc(0, 1, 24'h0000FF, 32'hCCAA5533); cyc(1, 0, 24'h0000FF, 0); idle(4);
        tag = "R3";
        cyc(1, 0, 24'h00370F, 0); cyc(0, 1, 24'h00370F, 32'hCA5335AC);
        cyc(1, 0, 24'h00370F, 0); cyc(1, 0, 24'h0000FF, 0); idle(4);
        tag = "R4";
        cyc(0, 1, 24'h0000FF, 32'h12345678); cyc(1, 0, 24'h0000FF, 0);
        cyc(1, 0, 24'h00370F, 0); cyc(1, 0, 24'h0000FF, 0); idle(6);
        tag = "R5";
        cyc(1, 0, 24'h0001FF, 0); idle(2); cyc(1, 0, 24'h0000FF, 0);
        cyc(1, 0, 24'h0000FE, 0); cyc(0, 1, 24'h00370E, 32'hDEADBEEF);
        cyc(0, 1, 24'hABCD0F, 32'hFEEDFACE); cyc(1, 0, 24'h00370F, 0); idle(4);
        tag = "R6";
        cyc(1, 0, 24'h0000FF, 0); cyc(1, 1, 24'h0000FF, 32'h0BADF00D);
        idle(3); cyc(1, 0, 24'h0000FF, 0); idle(4);
        tag = "R8";
        cyc(0, 1, 24'h0000FF, 32'h5A5A5A5A); cyc(0, 1, 24'h00370F, 32'hA5A5A5A5); idle(4);
        tag = "R1";
        for (int i = 0; i < 3000; i++) begin
            logic [23:0] a;
            int          op;
            case ($urandom_range(0, 6))
                0: a = 24'h0000FF;  1: a = 24'h00370F;  2: a = 24'h0000FE;
                3: a = 24'h00370E;  4: a = 24'h0037FF;  5: a = 24'h01000F;
                default: a = {16'h0000, 8'h0F};
            endcase
            op = $urandom_range(0, 9);
            cyc(op < 4, (op >= 4 && op < 7) || op == 9, a, $urandom);
        end
        idle(5);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule